// File: doc/BRIEF.md
# Sparse-Counter Syndrome Generator

This block forms the syndrome of a received word against a secret parity-check matrix made of two circulant blocks of size `R`. The matrix is never stored densely. Each block's first row is held as a short list of unsorted position counters, one for each set bit. The block streams the two halves of the received word together, one bit of each per step. When a bit is set, the current row of its block is XORed into an `R`-bit syndrome register at the counter positions. At the end of every step all counters advance by one, which yields the next cyclic row.

Software-facing logic loads the counters through a key port while the block is idle. It pulses `start`, supplies one bit pair each time `ct_req` is raised, and reads the syndrome word by word once `done` is high. The default mode spends the same number of cycles on every step whatever the key or data. An optional fast mode shortens steps whose two bits are both clear, but it still rotates the counters.

Top module: `sparse_syndrome_gen`

## Requirements
- R1: After reset `busy`, `done` and `ct_req` are low and every syndrome word reads zero.
- R2: A key write with `key_wr` high, `key_blk` choosing block 0 or 1 and `key_idx` below W/2 stores `key_pos` as a counter of that block. It is accepted only while `busy` is low; a write while busy has no effect on the result.
- R3: In each step `ct_req` is high for exactly one cycle. `ct_a` and `ct_b` are sampled at the clock edge that ends that cycle, and the n-th request (counting from 0) carries bit n of the first and second half.
- R4: At the end of each step every counter becomes its value plus one. A counter that reaches `R` becomes 0 through a mask and not through a branch, and counters are kept in no particular order.
- R5: After a run, the syndrome equals the XOR, over every step n with a set bit, of that block's first row rotated by n. A position that both blocks hit in the same step therefore cancels.
- R6: With `fast_mode` low at start, every step lasts exactly W/2+2 cycles and `busy` is high for exactly R·(W/2+2) cycles, for any key and data.
- R7: With `fast_mode` high at start, a step whose two bits are both clear lasts 2 cycles and any other step lasts W/2+2 cycles. The syndrome is the same as in the default mode.
- R8: A `start` accepted while idle clears the syndrome; `start` while busy is ignored.
- R9: `done` rises when the last step ends and stays high until the next accepted start. `rd_data` shows syndrome word `rd_addr`, where syndrome bit p sits in word p[15:5] at bit p[4:0]. Bits at positions R and above, and words beyond the last, read zero.
- R10: After R steps every counter holds its loaded value again, so a new run needs no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_wr | input | 1 | Counter write strobe |
| key_blk | input | 1 | Block selected by the write |
| key_idx | input | IDXW | Counter index within the block |
| key_pos | input | 16 | Bit position loaded into the counter |
| start | input | 1 | Begin a run |
| fast_mode | input | 1 | Skip accumulation for all-zero bit pairs |
| ct_req | output | 1 | Requests the next bit pair |
| ct_a | input | 1 | Bit of the first half |
| ct_b | input | 1 | Bit of the second half |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, syndrome valid |
| rd_addr | input | AW | Syndrome word index |
| rd_data | output | 32 | Syndrome word |

## Verification
Two writes into the syndrome can land on the same register bit in one cycle. This happens when a block-0 counter and a block-1 counter point at the same position while both stream bits are set. The bench loads such a key, sets both bits in a single step, and checks against a dense reference that the shared position has cancelled. In the same cycles the block can also receive a key write or a new `start`. The bench issues both in the middle of a run and judges them by the final syndrome and by the exact busy duration.

// File: rtl/syn_pkg.sv
// Shared types and fixed field widths for the syndrome generator.
// Assumes a 32-bit syndrome word and 16-bit position counters.
package syn_pkg;
    localparam int CNT_W   = 16;
    localparam int WORD_W  = 32;
    localparam int BSEL_W  = 5;
    localparam int WSEL_W  = CNT_W - BSEL_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_ACC  = 2'd2,
        ST_ROT  = 2'd3
    } seq_st_t;
endpackage

// File: rtl/row_counter_bank.sv
// Holds the set-bit positions of one circulant block's current row.
// Rotation adds one to every counter and wraps to zero with a mask built
// from the sign of (value+1-R), so every counter takes the same path.
// Assumes loaded positions are below R.
module row_counter_bank #(
    parameter int R    = 67,
    parameter int M    = 3,
    parameter int IDXW = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [IDXW-1:0]           ld_idx,
    input  logic [syn_pkg::CNT_W-1:0] ld_pos,
    input  logic                      rot_en,
    input  logic [IDXW-1:0]           rd_idx,
    output logic [syn_pkg::CNT_W-1:0] rd_pos
);
    import syn_pkg::*;

    logic [CNT_W-1:0] ctr     [M];
    logic [CNT_W-1:0] wrapped [M];

    genvar k;
    generate
        for (k = 0; k < M; k++) begin : g_wrap
            logic [CNT_W:0]   inc;
            logic [CNT_W:0]   diff;
            logic [CNT_W-1:0] keep;
            // Masked increment: keep the sum only while it stays below R.
            always_comb begin
                inc        = {1'b0, ctr[k]} + (CNT_W+1)'(1);
                diff       = inc - (CNT_W+1)'(R);
                keep       = {CNT_W{diff[CNT_W]}};
                wrapped[k] = inc[CNT_W-1:0] & keep;
            end

            // R4: a counter at R-1 returns to zero on rotation.
            assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (rot_en && !ld_en && ctr[k] == CNT_W'(R-1)) |=> (ctr[k] == '0));
            // R4: a counter below R-1 steps up by exactly one.
            assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (rot_en && !ld_en && ctr[k] < CNT_W'(R-1)) |=> (ctr[k] == $past(ctr[k]) + CNT_W'(1)));
        end
    endgenerate

    // Counter storage: load one entry or rotate all of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < M; i++) ctr[i] <= '0;
        end else if (ld_en) begin
            ctr[ld_idx] <= ld_pos;
        end else if (rot_en) begin
            for (int i = 0; i < M; i++) ctr[i] <= wrapped[i];
        end
    end

    // Read port for serial accumulation.
    assign rd_pos = ctr[rd_idx];
endmodule

// File: rtl/syndrome_store.sv
// R-bit syndrome held as 32-bit words. Two toggle ports each flip one bit
// per cycle; a position splits into word [15:5] and bit [4:0]. When both
// ports hit the same bit they cancel. Bits at R and above are never set.
module syndrome_store #(
    parameter int R      = 67,
    parameter int NWORDS = 3,
    parameter int AW     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       tog_a_en,
    input  logic [syn_pkg::CNT_W-1:0]  tog_a_pos,
    input  logic                       tog_b_en,
    input  logic [syn_pkg::CNT_W-1:0]  tog_b_pos,
    input  logic [AW-1:0]              rd_addr,
    output logic [syn_pkg::WORD_W-1:0] rd_word
);
    import syn_pkg::*;

    logic [WORD_W-1:0] syn_w [NWORDS];
    logic [WORD_W-1:0] tmask [NWORDS];

    logic [WSEL_W-1:0] a_word, b_word;
    logic [BSEL_W-1:0] a_bit,  b_bit;
    assign a_word = tog_a_pos[CNT_W-1:BSEL_W];
    assign a_bit  = tog_a_pos[BSEL_W-1:0];
    assign b_word = tog_b_pos[CNT_W-1:BSEL_W];
    assign b_bit  = tog_b_pos[BSEL_W-1:0];

    genvar w, b;
    generate
        for (w = 0; w < NWORDS; w++) begin : g_word
            for (b = 0; b < WORD_W; b++) begin : g_bit
                if (w * WORD_W + b < R) begin : g_live
                    // Flip request for this bit from either port.
                    assign tmask[w][b] =
                        (tog_a_en && a_word == WSEL_W'(w) && a_bit == BSEL_W'(b)) ^
                        (tog_b_en && b_word == WSEL_W'(w) && b_bit == BSEL_W'(b));
                end else begin : g_pad
                    assign tmask[w][b] = 1'b0;
                end
            end

            // Word register: clear on start, otherwise apply the flip mask.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) syn_w[w] <= '0;
                else               syn_w[w] <= syn_w[w] ^ tmask[w];
            end

            // R8: a clear leaves the word empty.
            assert_clear_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> (syn_w[w] == '0));
            // R5: without a toggle the word holds.
            assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && !tog_a_en && !tog_b_en) |=> $stable(syn_w[w]));
            // R5: two toggles on one position cancel.
            assert_pair_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && tog_a_en && tog_b_en && tog_a_pos == tog_b_pos) |=> $stable(syn_w[w]));
        end
    endgenerate

    // Read port; out-of-range words read zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NWORDS; i++)
            if (int'(rd_addr) == i) rd_word = syn_w[i];
    end
endmodule

// File: rtl/step_sequencer.sv
// Sequences a run of R steps. A step requests a bit pair (HEAD), walks the
// M counter pairs (ACC) and rotates all counters (ROT). Default mode always
// walks; fast mode skips the walk when both bits are clear.
module step_sequencer #(
    parameter int R    = 67,
    parameter int M    = 3,
    parameter int IDXW = 2,
    parameter int SW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            fast_mode,
    input  logic            ct_a,
    input  logic            ct_b,
    output logic            ct_req,
    output logic            busy,
    output logic            done,
    output logic [IDXW-1:0] acc_idx,
    output logic            acc_a,
    output logic            acc_b,
    output logic            rot_en,
    output logic            syn_clr
);
    import syn_pkg::*;

    localparam int GW = $clog2(M + 3) + 1;

    seq_st_t         st;
    logic [SW-1:0]   step_cnt;
    logic [IDXW-1:0] j;
    logic            bit_a, bit_b, fast_q, done_q;

    // State, step count, walk index and captured bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; step_cnt <= '0; j <= '0;
            bit_a <= 1'b0; bit_b <= 1'b0; fast_q <= 1'b0; done_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st <= ST_HEAD; step_cnt <= '0;
                    fast_q <= fast_mode; done_q <= 1'b0;
                end
                ST_HEAD: begin
                    bit_a <= ct_a; bit_b <= ct_b; j <= '0;
                    st <= (fast_q && !ct_a && !ct_b) ? ST_ROT : ST_ACC;
                end
                ST_ACC: begin
                    j <= j + IDXW'(1);
                    if (j == IDXW'(M - 1)) st <= ST_ROT;
                end
                ST_ROT: begin
                    step_cnt <= step_cnt + SW'(1);
                    if (step_cnt == SW'(R - 1)) begin
                        st <= ST_IDLE; done_q <= 1'b1;
                    end else begin
                        st <= ST_HEAD;
                    end
                end
            endcase
        end
    end

    // Decoded controls for the bank and the syndrome.
    always_comb begin
        ct_req  = (st == ST_HEAD);
        busy    = (st != ST_IDLE);
        acc_idx = j;
        acc_a   = (st == ST_ACC) & bit_a;
        acc_b   = (st == ST_ACC) & bit_b;
        rot_en  = (st == ST_ROT);
        syn_clr = (st == ST_IDLE) & start;
    end
    assign done = done_q;

    // Checker state: cycles since the last bit request within a run.
    logic [GW-1:0] gap;
    logic          seen;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            gap <= '0; seen <= 1'b0;
        end else if (ct_req) begin
            gap <= GW'(1); seen <= 1'b1;
        end else if (gap < GW'(M + 3)) begin
            gap <= gap + GW'(1);
        end
    end

    // R6: in default mode requests are spaced M+2 cycles apart.
    assert_step_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_req && seen && !fast_q) |-> (gap == GW'(M + 2)));
    // R7: in fast mode a step never takes fewer than 2 cycles.
    assert_fast_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_req && seen && fast_q) |-> (gap >= GW'(2)));
    // R9: done and busy never overlap.
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R3: the request comes from a running sequencer only.
    assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ct_req |-> (busy && !rot_en));
endmodule

// File: rtl/sparse_syndrome_gen.sv
// Top level: two counter banks, a sequencer and the syndrome store.
// Key writes go through only while idle and with an index below M.
module sparse_syndrome_gen #(
    parameter int R      = 67,
    parameter int W      = 6,
    parameter int M      = W / 2,
    parameter int IDXW   = (M > 1) ? $clog2(M) : 1,
    parameter int NWORDS = (R + syn_pkg::WORD_W - 1) / syn_pkg::WORD_W,
    parameter int AW     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       key_wr,
    input  logic                       key_blk,
    input  logic [IDXW-1:0]            key_idx,
    input  logic [syn_pkg::CNT_W-1:0]  key_pos,
    input  logic                       start,
    input  logic                       fast_mode,
    output logic                       ct_req,
    input  logic                       ct_a,
    input  logic                       ct_b,
    output logic                       busy,
    output logic                       done,
    input  logic [AW-1:0]              rd_addr,
    output logic [syn_pkg::WORD_W-1:0] rd_data
);
    import syn_pkg::*;

    localparam int SW = $clog2(R + 1);

    logic [IDXW-1:0]  acc_idx;
    logic             acc_a, acc_b, rot_en, syn_clr;
    logic             key_ok;
    logic [CNT_W-1:0] pos [2];
    logic [1:0]       ld_en;

    assign key_ok = key_wr && !busy && (int'(key_idx) < M);

    step_sequencer #(.R(R), .M(M), .IDXW(IDXW), .SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .fast_mode(fast_mode),
        .ct_a(ct_a), .ct_b(ct_b), .ct_req(ct_req), .busy(busy), .done(done),
        .acc_idx(acc_idx), .acc_a(acc_a), .acc_b(acc_b),
        .rot_en(rot_en), .syn_clr(syn_clr)
    );

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_bank
            assign ld_en[g] = key_ok && (key_blk == g[0]);
            row_counter_bank #(.R(R), .M(M), .IDXW(IDXW)) u_bank (
                .clk(clk), .rst_n(rst_n), .ld_en(ld_en[g]), .ld_idx(key_idx),
                .ld_pos(key_pos), .rot_en(rot_en), .rd_idx(acc_idx),
                .rd_pos(pos[g])
            );
        end
    endgenerate

    syndrome_store #(.R(R), .NWORDS(NWORDS), .AW(AW)) u_syn (
        .clk(clk), .rst_n(rst_n), .clr(syn_clr),
        .tog_a_en(acc_a), .tog_a_pos(pos[0]),
        .tog_b_en(acc_b), .tog_b_pos(pos[1]),
        .rd_addr(rd_addr), .rd_word(rd_data)
    );

    // R2: key writes never change the bank while running.
    assert_no_load_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ld_en == 2'b00));
    // R8: a clear happens only when a run is launched.
    assert_clear_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        syn_clr |=> (busy && !done));
endmodule

// File: tb/sim_sparse_syndrome_gen.sv
module sim_sparse_syndrome_gen;
    localparam int RR = 67;
    localparam int WW = 6;
    localparam int M  = WW / 2;
    localparam int NW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr = 1'b0, key_blk = 1'b0;
    logic [1:0]  key_idx = '0;
    logic [15:0] key_pos = '0;
    logic        start = 1'b0, fast_mode = 1'b0;
    logic        ct_a = 1'b0, ct_b = 1'b0;
    logic        ct_req, busy, done;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;

    always #10 clk = ~clk;

    sparse_syndrome_gen #(.R(RR), .W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_blk(key_blk),
        .key_idx(key_idx), .key_pos(key_pos), .start(start),
        .fast_mode(fast_mode), .ct_req(ct_req), .ct_a(ct_a), .ct_b(ct_b),
        .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0, failures = 0;
    bit va [RR];
    bit vb [RR];
    int feed = 0;
    int busy_cyc = 0;
    bit cmp_on = 0;

    // Behavioural reference: phases, step count, key lists, dense syndrome.
    int m_ph = 0, m_j = 0, m_step = 0;
    bit m_fast = 0, m_done = 0;
    int mk0 [M];
    int mk1 [M];
    bit ms [RR];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_done = 0; m_step = 0;
            for (int i = 0; i < M; i++) begin mk0[i] = 0; mk1[i] = 0; end
            for (int i = 0; i < RR; i++) ms[i] = 0;
        end else begin
            if (key_wr && m_ph == 0 && int'(key_idx) < M) begin
                if (key_blk) mk1[key_idx] = key_pos; else mk0[key_idx] = key_pos;
            end
            case (m_ph)
                0: if (start) begin
                    m_ph = 1; m_step = 0; m_fast = fast_mode; m_done = 0;
                    for (int i = 0; i < RR; i++) ms[i] = 0;
                end
                1: begin
                    for (int k = 0; k < M; k++) begin
                        if (ct_a) ms[(mk0[k] + m_step) % RR] ^= 1'b1;
                        if (ct_b) ms[(mk1[k] + m_step) % RR] ^= 1'b1;
                    end
                    m_j = 0;
                    m_ph = (m_fast && !ct_a && !ct_b) ? 3 : 2;
                end
                2: begin m_j++; if (m_j == M) m_ph = 3; end
                default: begin
                    m_step++;
                    if (m_step == RR) begin m_ph = 0; m_done = 1; end
                    else m_ph = 1;
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison of handshake outputs; also feeds bits on request.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check(ct_req == (m_ph == 1), "R3", "ct_req", ct_req, m_ph == 1);
            check(busy == (m_ph != 0), "R6", "busy", busy, m_ph != 0);
            check(done == m_done, "R9", "done", done, m_done);
        end
        if (busy) busy_cyc++;
        if (ct_req) begin
            ct_a = (feed < RR) ? va[feed] : 1'b0;
            ct_b = (feed < RR) ? vb[feed] : 1'b0;
            feed++;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic write_key(input bit blk, input int idx, input int p);
        @(negedge clk);
        key_wr = 1'b1; key_blk = blk; key_idx = 2'(idx); key_pos = 16'(p);
        @(negedge clk);
        key_wr = 1'b0;
    endtask

    task automatic clear_vec();
        for (int i = 0; i < RR; i++) begin va[i] = 0; vb[i] = 0; end
    endtask

    task automatic fill_vec(input int seed);
        int x = seed;
        for (int i = 0; i < RR; i++) begin
            x = x * 1103515245 + 12345; va[i] = x[16];
            x = x * 1103515245 + 12345; vb[i] = x[18];
        end
    endtask

    function automatic int fast_len();
        int t = 0;
        for (int i = 0; i < RR; i++) t += (va[i] || vb[i]) ? (M + 2) : 2;
        return t;
    endfunction

    task automatic run(input bit fast, input bit poke);
        @(negedge clk);
        feed = 0; busy_cyc = 0;
        start = 1'b1; fast_mode = fast;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R9", "done low after start", done, 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            key_wr = 1'b1; key_blk = 1'b0; key_idx = 2'd1; key_pos = 16'd10;
            start = 1'b1;
            @(negedge clk);
            key_wr = 1'b0; start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    task automatic check_model(input string req);
        for (int w = 0; w < NW; w++) begin
            logic [31:0] e = '0;
            for (int b = 0; b < 32; b++)
                if (w * 32 + b < RR) e[b] = ms[w * 32 + b];
            rd_addr = 2'(w); #1;
            check(rd_data == e, req, $sformatf("syndrome word %0d", w), rd_data, e);
        end
    endtask

    task automatic check_word(input int w, input logic [31:0] e, input string req);
        rd_addr = 2'(w); #1;
        check(rd_data == e, req, $sformatf("explicit word %0d", w), rd_data, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(!busy && !done && !ct_req, "R1", "flags after reset",
              {busy, done, ct_req}, 0);
        for (int w = 0; w < NW; w++) check_word(w, 32'h0, "R1");
        cmp_on = 1;

        // Key: block 0 {66,0,31}, block 1 {5,40,32}.
        write_key(0, 0, 66); write_key(0, 1, 0); write_key(0, 2, 31);
        write_key(1, 0, 5);  write_key(1, 1, 40); write_key(1, 2, 32);

        // R2/R5: single bit at step 0 exposes the block-0 row.
        clear_vec(); va[0] = 1;
        run(0, 0);
        check_word(0, 32'h8000_0001, "R2");
        check_word(1, 32'h0, "R2");
        check_word(2, 32'h0000_0004, "R2");
        check_model("R5");
        check(busy_cyc == RR * (M + 2), "R6", "busy cycles default", busy_cyc, RR * (M + 2));

        // R4: bit at the last step makes every counter wrap once.
        clear_vec(); va[RR - 1] = 1;
        run(1, 0);
        check_word(0, 32'h4000_0000, "R4");
        check_word(2, 32'h0000_0006, "R4");
        check(busy_cyc == fast_len(), "R7", "busy cycles fast sparse", busy_cyc, fast_len());

        // R5/R6/R10: mixed data, default mode, no reload.
        fill_vec(7);
        run(0, 0);
        check_model("R10");
        check(busy_cyc == RR * (M + 2), "R6", "busy cycles mixed", busy_cyc, RR * (M + 2));

        // R7: same data in fast mode gives the same syndrome.
        run(1, 0);
        check_model("R7");
        check(busy_cyc == fast_len(), "R7", "busy cycles fast", busy_cyc, fast_len());

        // R5: shared position in both blocks cancels.
        write_key(1, 0, 66);
        clear_vec(); va[3] = 1; vb[3] = 1;
        run(0, 0);
        check_word(0, 32'h0000_0008, "R5");
        check_word(1, 32'h0000_080C, "R5");
        check_word(2, 32'h0, "R5");

        // R2/R8: key write and start during a run are ignored.
        fill_vec(99);
        run(0, 1);
        check_model("R2");
        check(busy_cyc == RR * (M + 2), "R8", "busy cycles with restart", busy_cyc, RR * (M + 2));

        // R8: new start clears old result.
        clear_vec();
        run(1, 0);
        for (int w = 0; w < NW; w++) check_word(w, 32'h0, "R8");

        // R9: done holds and an out-of-range word reads zero.
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R9", "done held", done, 1);
        check_word(3, 32'h0, "R9");

        cmp_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule